// File: doc/BRIEF.md
# I2C Slave Address Recognizer

This block sits on a two-wire serial bus as a slave and decides whether it is being addressed. It samples the clock and data lines on the system clock, finds the START condition, shifts in the following address byte and compares its upper seven bits with a programmable own address. If bit 0 of the address register is set, the all-zero general call byte also counts as a hit. On a hit, with acknowledge enabled, it pulls the data line low for the acknowledge bit. It then reports itself selected and raises an interrupt request.

While the interrupt request is pending, the block pulls the clock line low, which stalls the master until software clears the request. A STOP condition or a repeated START seen while selected also raises the request. A software recovery pulse drops the block back to the not-selected state at once, without disturbing the bus. The block has no bit-rate setting: it follows whatever clock the master supplies. Data bytes after selection are handled elsewhere.

Top module: `i2c_addr_sel`

## Requirements
- R1: After reset, the data pull-down, clock pull-down, selected, general-call, direction and interrupt outputs are all 0.
- R2: With ack_en=1, an address byte whose bits 7..1 equal own_addr[7:1] is acknowledged. The data pull-down is 1 while the clock is high during the ninth bit. After the ninth falling clock edge, selected=1, irq=1, rw_dir equals bit 0 of the byte (1 = read), and gen_call=0 unless R3 applies.
- R3: With ack_en=1 and own_addr[0]=1, the byte 00h is acknowledged and leads to selected=1, irq=1 and gen_call=1.
- R4: With own_addr[0]=0, the byte 00h is not acknowledged and raises no interrupt, as long as own_addr[7:1] is not 0.
- R5: With ack_en=0, no address byte is acknowledged, and none sets selected or irq.
- R6: An address byte that matches neither the own address nor an enabled general call is not acknowledged and leaves irq at 0, even after a later STOP.
- R7: While irq=1, the clock pull-down is 1. A pulse on irq_clr clears irq and releases the clock line.
- R8: A STOP condition (data rising while the clock is high) seen while selected sets irq and clears selected.
- R9: A repeated START seen while selected sets irq, clears selected, and evaluates the following address byte afresh.
- R10: A stop_recover pulse clears selected, irq and both pull-downs within a few cycles and generates nothing on the bus. A later STOP then raises no interrupt.
- R11: Address bits are taken only after a START (data falling while the clock is high), most significant bit first, on rising clock edges. A byte clocked in without a preceding START is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| own_addr | input | 8 | Bits 7..1 own address, bit 0 general-call enable |
| ack_en | input | 1 | Permits acknowledge and interrupt on a hit |
| irq_clr | input | 1 | Single-cycle software clear of the interrupt flag |
| stop_recover | input | 1 | Single-cycle software recovery to not-selected |
| sda_pull | output | 1 | Drives the data line low when 1 |
| scl_pull | output | 1 | Drives the clock line low when 1 |
| selected | output | 1 | Block has been addressed |
| gen_call | output | 1 | Selection came from the general call byte |
| rw_dir | output | 1 | Direction bit of the selecting byte |
| irq | output | 1 | Interrupt request flag |

## Verification
The bench uses the default parameters: a 7-bit address with an 8-bit shift byte, and two synchroniser stages. With these settings, a change on a line reaches the state three system clocks later. The bench master holds every bus phase for six system clocks, so each sample lands after the design has settled and well before the next bus phase. A fixed 7-bit address width lets the random part hit the own address, single-bit neighbours of it, and the all-zero byte often, alongside arbitrary bytes.

// File: rtl/i2c_sar_pkg.sv
package i2c_sar_pkg;
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ADDR    = 3'd1,
        ST_ACKWAIT = 3'd2,
        ST_ACK     = 3'd3,
        ST_SEL     = 3'd4
    } sar_state_e;
endpackage

// File: rtl/sar_sync.sv
module sar_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    // one flop chain per line, reset to the idle-high bus level
    for (genvar w = 0; w < WIDTH; w++) begin : g_line
        logic [STAGES-1:0] chain_d, chain_q;
        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_in[w]};
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= chain_d;
        end
        assign sync_out[w] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/sar_bus_events.sv
module sar_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic scl;
        logic sda;
    } prev_t;

    prev_t prev_d, prev_q;

    always_comb begin
        prev_d.scl = scl_s;
        prev_d.sda = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '{scl: 1'b1, sda: 1'b1};
        else        prev_q <= prev_d;
    end

    assign scl_rise  =  scl_s & ~prev_q.scl;
    assign scl_fall  = ~scl_s &  prev_q.scl;
    assign start_det =  scl_s &  prev_q.scl &  prev_q.sda & ~sda_s;
    assign stop_det  =  scl_s &  prev_q.scl & ~prev_q.sda &  sda_s;
endmodule

// File: rtl/sar_addr_fsm.sv
module sar_addr_fsm
    import i2c_sar_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_bit,
    input  logic [ADDR_W:0]   own_addr,
    input  logic              ack_en,
    input  logic              irq_clr,
    input  logic              stop_recover,
    output logic              sda_pull,
    output logic              selected,
    output logic              gen_call,
    output logic              rw_dir,
    output logic              irq
);
    localparam int BYTE_W = ADDR_W + 1;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef struct packed {
        sar_state_e          state;
        logic [CNT_W-1:0]    cnt;
        logic [BYTE_W-1:0]   sreg;
        logic                gc_pend;
        logic                sda_pull;
        logic                selected;
        logic                gen_call;
        logic                rw_dir;
        logic                irq;
    } fsm_t;

    fsm_t cur_q, nxt_d;

    logic [BYTE_W-1:0] byte_new;
    logic              own_hit, gc_hit;

    always_comb begin
        byte_new = {cur_q.sreg[BYTE_W-2:0], sda_bit};
        own_hit  = (byte_new[BYTE_W-1:1] == own_addr[BYTE_W-1:1]);
        gc_hit   = (byte_new == '0) && own_addr[0];
    end

    always_comb begin
        nxt_d     = cur_q;
        nxt_d.irq = cur_q.irq & ~irq_clr;

        unique case (cur_q.state)
            ST_ADDR: begin
                if (scl_rise) begin
                    nxt_d.sreg = byte_new;
                    if (cur_q.cnt == CNT_W'(BYTE_W - 1)) begin
                        nxt_d.cnt     = '0;
                        nxt_d.gc_pend = gc_hit;
                        nxt_d.state   = (ack_en && (own_hit || gc_hit)) ? ST_ACKWAIT : ST_IDLE;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
            end
            ST_ACKWAIT: begin
                if (scl_fall) begin
                    nxt_d.sda_pull = 1'b1;
                    nxt_d.state    = ST_ACK;
                end
            end
            ST_ACK: begin
                if (scl_fall) begin
                    nxt_d.sda_pull = 1'b0;
                    nxt_d.selected = 1'b1;
                    nxt_d.irq      = 1'b1;
                    nxt_d.gen_call = cur_q.gc_pend;
                    nxt_d.rw_dir   = cur_q.sreg[0];
                    nxt_d.state    = ST_SEL;
                end
            end
            default: ;
        endcase

        if (start_det || stop_det) begin
            if (cur_q.selected) nxt_d.irq = 1'b1;
            nxt_d.state    = start_det ? ST_ADDR : ST_IDLE;
            nxt_d.cnt      = '0;
            nxt_d.sda_pull = 1'b0;
            nxt_d.selected = 1'b0;
            nxt_d.gen_call = 1'b0;
            nxt_d.gc_pend  = 1'b0;
        end

        if (stop_recover) begin
            nxt_d.state    = ST_IDLE;
            nxt_d.cnt      = '0;
            nxt_d.sda_pull = 1'b0;
            nxt_d.selected = 1'b0;
            nxt_d.gen_call = 1'b0;
            nxt_d.gc_pend  = 1'b0;
            nxt_d.irq      = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, cnt: '0, sreg: '0, gc_pend: 1'b0,
                       sda_pull: 1'b0, selected: 1'b0, gen_call: 1'b0,
                       rw_dir: 1'b0, irq: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign sda_pull = cur_q.sda_pull;
    assign selected = cur_q.selected;
    assign gen_call = cur_q.gen_call;
    assign rw_dir   = cur_q.rw_dir;
    assign irq      = cur_q.irq;

    // R10
    recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_recover |=> (!selected && !sda_pull && !irq));

    // R7
    irq_clear_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(irq_clr || stop_recover));

    // R2
    sel_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected) |-> irq);

    // R8
    stop_while_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det && selected && !stop_recover) |=> (irq && !selected));

    // R2
    ack_before_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sda_pull |-> !selected);
endmodule

// File: rtl/i2c_addr_sel.sv
module i2c_addr_sel #(
    parameter int ADDR_W      = 7,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_in,
    input  logic              sda_in,
    input  logic [ADDR_W:0]   own_addr,
    input  logic              ack_en,
    input  logic              irq_clr,
    input  logic              stop_recover,
    output logic              sda_pull,
    output logic              scl_pull,
    output logic              selected,
    output logic              gen_call,
    output logic              rw_dir,
    output logic              irq
);
    logic [1:0] line_s;
    logic scl_rise, scl_fall, start_det, stop_det;

    sar_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({scl_in, sda_in}),
        .sync_out (line_s)
    );

    sar_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (line_s[1]),
        .sda_s     (line_s[0]),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    sar_addr_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_rise     (scl_rise),
        .scl_fall     (scl_fall),
        .start_det    (start_det),
        .stop_det     (stop_det),
        .sda_bit      (line_s[0]),
        .own_addr     (own_addr),
        .ack_en       (ack_en),
        .irq_clr      (irq_clr),
        .stop_recover (stop_recover),
        .sda_pull     (sda_pull),
        .selected     (selected),
        .gen_call     (gen_call),
        .rw_dir       (rw_dir),
        .irq          (irq)
    );

    assign scl_pull = irq;

    // R7
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr && !stop_recover) |=> scl_pull);
endmodule

// File: tb/i2c_addr_sel_test.sv
module i2c_addr_sel_test;
    localparam int CLK_PERIOD = 10;
    localparam int HP         = 6;
    localparam int WD_CYCLES  = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic [7:0] own_addr = 8'h00;
    logic ack_en = 1'b0, irq_clr = 1'b0, stop_recover = 1'b0;
    logic sda_pull, scl_pull, selected, gen_call, rw_dir, irq;
    logic scl_line, sda_line;

    int n_chk = 0, n_bad = 0, cyc = 0;

    assign scl_line = scl_m & ~scl_pull;
    assign sda_line = sda_m & ~sda_pull;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_addr_sel uut (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_line), .sda_in(sda_line),
        .own_addr(own_addr), .ack_en(ack_en), .irq_clr(irq_clr),
        .stop_recover(stop_recover), .sda_pull(sda_pull), .scl_pull(scl_pull),
        .selected(selected), .gen_call(gen_call), .rw_dir(rw_dir), .irq(irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == WD_CYCLES) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < %0d)", cyc, WD_CYCLES);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(HP);
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b0; tick(HP);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; tick(HP);
        scl_m = 1'b1; tick(HP);
        sda_m = 1'b1; tick(HP);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ackd);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(HP);
            scl_m = 1'b1; tick(HP);
            scl_m = 1'b0; tick(HP);
        end
        sda_m = 1'b1; tick(HP);
        scl_m = 1'b1; tick(HP);
        ackd = sda_pull;
        scl_m = 1'b0; tick(HP);
    endtask

    task automatic sw_clear();
        irq_clr = 1'b1; tick(1);
        irq_clr = 1'b0; tick(1);
    endtask

    function automatic logic exp_hit(input logic [7:0] own, input logic aen, input logic [7:0] b);
        return aen && ((b[7:1] == own[7:1]) || (b == 8'h00 && own[0]));
    endfunction

    logic ack;

    initial begin
        void'($urandom(32'd24680));
        tick(3);
        // R1
        chk("R1", "sda_pull", {7'd0, sda_pull}, 8'd0);
        chk("R1", "scl_pull", {7'd0, scl_pull}, 8'd0);
        chk("R1", "selected", {7'd0, selected}, 8'd0);
        chk("R1", "flags", {5'd0, gen_call, rw_dir, irq}, 8'd0);
        rst_n = 1'b1; tick(4);

        // R11: byte clocked without START is ignored
        own_addr = 8'hA4; ack_en = 1'b1;
        send_byte(8'hA4, ack);
        chk("R11", "ack without start", {7'd0, ack}, 8'd0);
        chk("R11", "irq without start", {7'd0, irq}, 8'd0);
        sda_m = 1'b1; scl_m = 1'b1; tick(HP);

        // R2 directed, read direction, then R9 repeated start
        bus_start(); send_byte(8'hA5, ack);
        chk("R2", "ack", {7'd0, ack}, 8'd1);
        chk("R2", "selected", {7'd0, selected}, 8'd1);
        chk("R2", "rw_dir", {7'd0, rw_dir}, 8'd1);
        sw_clear();
        sda_m = 1'b1; tick(HP); scl_m = 1'b1; tick(HP);
        sda_m = 1'b0; tick(HP); scl_m = 1'b0; tick(HP);
        chk("R9", "irq on rep start", {7'd0, irq}, 8'd1);
        chk("R9", "selected after rep start", {7'd0, selected}, 8'd0);
        sw_clear();
        send_byte(8'h30, ack);
        chk("R9", "new byte mismatch ack", {7'd0, ack}, 8'd0);
        chk("R9", "new byte irq", {7'd0, irq}, 8'd0);
        bus_stop();

        // R10 recovery while selected and stretching
        bus_start(); send_byte(8'hA4, ack);
        chk("R10", "selected before", {7'd0, selected}, 8'd1);
        stop_recover = 1'b1; tick(1); stop_recover = 1'b0; tick(3);
        chk("R10", "pulls", {6'd0, sda_pull, scl_pull}, 8'd0);
        chk("R10", "sel/irq", {6'd0, selected, irq}, 8'd0);
        chk("R10", "bus lines", {6'd0, sda_line, scl_line}, {6'd0, sda_m, scl_m});
        bus_stop();
        chk("R10", "irq after stop", {7'd0, irq}, 8'd0);

        // random mix with directed kinds
        for (int it = 0; it < 48; it++) begin
            logic [7:0] own, b;
            logic aen, hit, gcx;
            int kind;
            string rq;
            own  = 8'($urandom);
            if (own[7:1] == 7'd0) own[7:1] = 7'h11;
            aen  = ($urandom % 5) != 0;
            kind = int'($urandom % 4);
            case (kind)
                0: b = {own[7:1], 1'($urandom)};
                1: b = 8'h00;
                2: b = 8'($urandom);
                default: b = {own[7:1] ^ (7'd1 << ($urandom % 7)), 1'($urandom)};
            endcase
            own_addr = own; ack_en = aen;
            hit = exp_hit(own, aen, b);
            gcx = (b == 8'h00) && own[0];
            rq  = !aen ? "R5" : (b == 8'h00) ? (own[0] ? "R3" : "R4") : (hit ? "R2" : "R6");
            bus_start(); send_byte(b, ack);
            chk(rq, "ack", {7'd0, ack}, {7'd0, hit});
            chk(rq, "selected", {7'd0, selected}, {7'd0, hit});
            chk(rq, "irq", {7'd0, irq}, {7'd0, hit});
            chk("R7", "scl_pull", {7'd0, scl_pull}, {7'd0, hit});
            if (hit) begin
                chk(rq, "gen_call", {7'd0, gen_call}, {7'd0, gcx});
                chk(rq, "rw_dir", {7'd0, rw_dir}, {7'd0, b[0]});
                sw_clear();
                chk("R7", "irq cleared", {7'd0, irq}, 8'd0);
                chk("R7", "scl released", {7'd0, scl_pull}, 8'd0);
                bus_stop();
                chk("R8", "irq on stop", {7'd0, irq}, 8'd1);
                chk("R8", "deselected", {7'd0, selected}, 8'd0);
                sw_clear();
            end else begin
                bus_stop();
                chk("R6", "irq after stop", {7'd0, irq}, 8'd0);
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule